// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns 32-bit linear addresses into physical addresses by walking a two-level translation tree kept in ordinary memory. A requester presents a linear address on a valid/ready port and later receives either a physical address or a fault. The top ten bits of the linear address choose an entry in a root directory, whose location comes from a base input. That entry points at a second-level table, and the middle ten bits choose an entry there. The second entry supplies the 4 KB physical frame, and the low twelve bits pass through as the byte offset.

Each walk costs two memory reads, so a small fully associative cache of recent translations sits in front of the walker. A hit answers on the next cycle without touching memory. A miss starts a walk over a simple read port that has one read in flight at a time. A successful walk fills the cache, choosing the victim in round-robin order. A flush input empties the cache in one cycle.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0.
- R2: On a miss, the first read address is `{root_base[31:12], 12'h000}` plus 4 times linear bits 31:22.
- R3: The second read address is `{dir_entry[31:12], 12'h000}` plus 4 times linear bits 21:12, where `dir_entry` is the data returned by the first read.
- R4: A successful walk responds with `rsp_fault`=0 and `rsp_phys` = `{tbl_entry[31:12], lin[11:0]}`, one cycle after the second read data arrives.
- R5: If bit 0 (present) of the directory entry is 0, the walk stops after one read and responds with `rsp_fault`=1 and `rsp_phys`=0.
- R6: If bit 0 of the table entry is 0, the response has `rsp_fault`=1 and nothing is cached, so a repeat of the same request walks again with two reads.
- R7: A request whose linear page is cached is answered one cycle after acceptance, with no memory read.
- R8: While a walk is in progress, `req_ready` is 0. At most one memory read is outstanding: `mem_req_valid` stays low while the walker waits for read data.
- R9: The cache holds 8 entries with round-robin replacement. After 9 distinct pages are filled following a flush, the first page misses and the third still hits.
- R10: Driving `flush` for one cycle invalidates every cached translation, so every later request walks again.
- R11: Two linear pages may map to the same physical frame. Both translate correctly, and both are cached side by side.
- R12: While `mem_req_valid` is 1 and `mem_req_ready` is 0, `mem_req_valid` stays 1 and `mem_req_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| root_base | input | 32 | Root directory base; bits 31:12 are used |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Ready to accept a request |
| req_lin | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed because an entry was not present |
| rsp_phys | output | 32 | Physical address; 0 on fault |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data (table entry) |

## Verification
The bench goes after present-bit faults at each level. A design that cached a failed second-level lookup would answer a repeat request with no reads. A design that kept walking past an absent directory entry would issue a second read. The bench stalls the memory request port every third cycle, so a walker that drops or changes the address under back-pressure shows up as a mis-addressed read. It also fills nine pages after a flush to probe the victim order. A wrong pointer evicts the wrong page and turns an expected hit into a walk. Aliased pages and a flush before a repeat request check that the cache is keyed by linear page only and that it truly empties.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
  localparam int ADDR_W    = 32;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 10;
  localparam int VPN_W     = ADDR_W - OFF_W;
  localparam int PFN_W     = ADDR_W - OFF_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_TBL_REQ,
    ST_TBL_WAIT
  } walk_st_t;

  function automatic logic [IDX_W-1:0] dir_index(input logic [ADDR_W-1:0] lin);
    return lin[ADDR_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] tbl_index(input logic [ADDR_W-1:0] lin);
    return lin[OFF_W+IDX_W-1 -: IDX_W];
  endfunction

  // address of entry idx in the table whose base sits in bits 31:12 of base
  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [IDX_W-1:0]  idx);
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] off;
    aligned = {base[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    off     = {{(ADDR_W-IDX_W-2){1'b0}}, idx, 2'b00};
    return aligned + off;
  endfunction

  function automatic logic present(input logic [ADDR_W-1:0] ent);
    return ent[0];
  endfunction

  function automatic logic [PFN_W-1:0] frame_of(input logic [ADDR_W-1:0] ent);
    return ent[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [ADDR_W-1:0] join_phys(input logic [PFN_W-1:0] pfn,
                                                  input logic [ADDR_W-1:0] lin);
    return {pfn, lin[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache
  import pw_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [PTR_W-1:0]   ptr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        pfn_q[g] <= '0;
      end else if (flush) begin
        vld_q[g] <= 1'b0;
      end else if (fill_en && (ptr_q == PTR_W'(g))) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= fill_vpn;
        pfn_q[g] <= fill_pfn;
      end
    end
  end

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_pfn = lk_pfn | pfn_q[i];
    end
  end

  assign lk_hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      ptr_q <= '0;
    end else if (fill_en) begin
      ptr_q <= (ptr_q == PTR_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/walk_ctrl.sv
`timescale 1ns/1ps
module walk_ctrl
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_lin,
  input  logic [ADDR_W-1:0] root_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              busy,
  output logic              waiting,
  output logic              done,
  output logic              done_fault,
  output logic [PFN_W-1:0]  done_pfn,
  output logic [ADDR_W-1:0] done_lin
);
  walk_st_t          st_q;
  logic [ADDR_W-1:0] lin_q;
  logic [ADDR_W-1:0] root_q;
  logic [ADDR_W-1:0] dent_q;

  logic dir_bad;
  logic tbl_end;

  assign dir_bad = (st_q == ST_DIR_WAIT) && mem_rsp_valid && !present(mem_rsp_data);
  assign tbl_end = (st_q == ST_TBL_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lin_q  <= '0;
      root_q <= '0;
      dent_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_DIR_REQ;
          lin_q  <= start_lin;
          root_q <= root_base;
        end
        ST_DIR_REQ:  if (mem_req_ready) st_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (mem_rsp_valid) begin
          if (present(mem_rsp_data)) begin
            dent_q <= mem_rsp_data;
            st_q   <= ST_TBL_REQ;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_TBL_REQ:  if (mem_req_ready) st_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: if (mem_rsp_valid) st_q <= ST_IDLE;
        default:     st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_addr  = '0;
    if (st_q == ST_DIR_REQ) begin
      mem_req_valid = 1'b1;
      mem_req_addr  = entry_addr(root_q, dir_index(lin_q));
    end else if (st_q == ST_TBL_REQ) begin
      mem_req_valid = 1'b1;
      mem_req_addr  = entry_addr(dent_q, tbl_index(lin_q));
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign waiting    = (st_q == ST_DIR_WAIT) || (st_q == ST_TBL_WAIT);
  assign done       = dir_bad || tbl_end;
  assign done_fault = dir_bad || (tbl_end && !present(mem_rsp_data));
  assign done_pfn   = frame_of(mem_rsp_data);
  assign done_lin   = lin_q;
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import pw_pkg::*;
#(
  parameter int CACHE_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic [31:0] root_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_lin,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [31:0] rsp_phys,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  // named internal events, visible to the checker
  logic              accept;
  logic              cache_hit;
  logic [PFN_W-1:0]  cache_pfn;
  logic              walk_start;
  logic              walk_busy;
  logic              walk_waiting;
  logic              walk_done;
  logic              walk_fault;
  logic [PFN_W-1:0]  walk_pfn;
  logic [ADDR_W-1:0] walk_lin;
  logic              fill_en;

  xlat_cache #(.ENTRIES(CACHE_ENTRIES)) u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_vpn   (req_lin[ADDR_W-1:OFF_W]),
    .lk_hit   (cache_hit),
    .lk_pfn   (cache_pfn),
    .fill_en  (fill_en),
    .fill_vpn (walk_lin[ADDR_W-1:OFF_W]),
    .fill_pfn (walk_pfn)
  );

  walk_ctrl u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (walk_start),
    .start_lin     (req_lin),
    .root_base     (root_base),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .busy          (walk_busy),
    .waiting       (walk_waiting),
    .done          (walk_done),
    .done_fault    (walk_fault),
    .done_pfn      (walk_pfn),
    .done_lin      (walk_lin)
  );

  assign req_ready  = !walk_busy;
  assign accept     = req_valid && req_ready;
  logic  use_hit;
  assign use_hit    = accept && cache_hit && !flush;
  assign walk_start = accept && !use_hit;
  assign fill_en    = walk_done && !walk_fault && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_phys  <= '0;
    end else begin
      rsp_valid <= use_hit || walk_done;
      rsp_fault <= walk_done && walk_fault;
      if (use_hit)                      rsp_phys <= join_phys(cache_pfn, req_lin);
      else if (walk_done && !walk_fault) rsp_phys <= join_phys(walk_pfn, walk_lin);
      else                              rsp_phys <= '0;
    end
  end
endmodule

// File: rtl/pw_chk.sv
`timescale 1ns/1ps
module pw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [31:0] rsp_phys,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        cache_hit,
  input logic        walk_busy,
  input logic        walk_waiting,
  input logic        walk_done,
  input logic        walk_fault,
  input logic        fill_en
);
  // R8
  ready_low_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |-> !req_ready);

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_waiting |-> !mem_req_valid);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R7
  hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cache_hit && !flush) |=> (rsp_valid && !rsp_fault));

  // R6
  no_fault_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_fault) |-> !fill_en);

  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_phys == 32'h0));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !cache_hit);
endmodule

bind pt_walker pw_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush         (flush),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .rsp_phys      (rsp_phys),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .cache_hit     (cache_hit),
  .walk_busy     (walk_busy),
  .walk_waiting  (walk_waiting),
  .walk_done     (walk_done),
  .walk_fault    (walk_fault),
  .fill_en       (fill_en)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] root_base = 32'h0010_0000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = 32'h0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_phys;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  pt_walker u0 (.*);

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;

  // memory model state
  logic [31:0] mem [logic [31:0]];
  int          rd_count = 0;
  logic [31:0] rd_log [$];
  bit          ol_bad = 0, hold_bad = 0, rdy_bad = 0;

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] exp_dir_addr(input logic [31:0] lin);
    return (root_base & 32'hFFFF_F000) + ((lin >> 22) * 4);
  endfunction

  function automatic logic [31:0] exp_tbl_addr(input logic [31:0] dent, input logic [31:0] lin);
    return (dent & 32'hFFFF_F000) + (((lin >> 12) & 32'h3FF) * 4);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // directory entry for dir d points at table 0x0020_0000 + d*4K
  task automatic map_page(input logic [31:0] lin, input logic [31:0] frame);
    logic [31:0] tbase = 32'h0020_0000 + ((lin >> 22) << 12);
    mem[exp_dir_addr(lin)] = tbase | 32'h1;
    mem[exp_tbl_addr(tbase, lin)] = (frame & 32'hFFFF_F000) | 32'h1;
  endtask

  initial begin
    int tick = 0;
    bit pend = 0;
    int cnt = 0;
    logic [31:0] pend_addr = 0;
    bit was_stalled = 0;
    logic [31:0] stall_addr = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    forever begin
      @(negedge clk);
      tick++;
      if (pend && mem_req_valid) ol_bad = 1;
      if (mem_req_valid && req_ready) rdy_bad = 1;
      if (was_stalled && (!mem_req_valid || mem_req_addr != stall_addr)) hold_bad = 1;
      mem_rsp_valid = 0;
      if (pend) begin
        if (cnt == 1) begin
          mem_rsp_valid = 1;
          mem_rsp_data = rd_mem(pend_addr);
          pend = 0;
        end else cnt--;
      end
      mem_req_ready = (tick % 3 != 0);
      was_stalled = mem_req_valid && !mem_req_ready;
      stall_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1; cnt = 2; pend_addr = mem_req_addr;
        rd_count++;
        rd_log.push_back(mem_req_addr);
      end
    end
  end

  task automatic xlate(input logic [31:0] lin, output logic [31:0] ph, output logic f,
                       output int nrd, output int lat);
    int r0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = rd_count;
    rd_log.delete();
    req_valid = 1; req_lin = lin;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_valid && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    ph = rsp_phys; f = rsp_fault; nrd = rd_count - r0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1, "R1", "req_ready after reset", {31'h0, req_ready}, 32'h1);
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    chk(mem_req_valid == 0, "R1", "mem_req_valid after reset", {31'h0, mem_req_valid}, 32'h0);
  endtask

  task automatic t_walk();
    logic [31:0] ph; logic f; int n, l;
    logic [31:0] lin = 32'h0040_3ABC;
    map_page(lin, 32'h8765_4000);
    xlate(lin, ph, f, n, l);
    chk(n == 2, "R2", "reads on miss", n, 2);
    if (rd_log.size() == 2) begin
      chk(rd_log[0] == exp_dir_addr(lin), "R2", "dir read addr", rd_log[0], exp_dir_addr(lin));
      chk(rd_log[1] == exp_tbl_addr(rd_mem(exp_dir_addr(lin)), lin), "R3", "tbl read addr",
          rd_log[1], exp_tbl_addr(rd_mem(exp_dir_addr(lin)), lin));
    end
    chk(!f, "R4", "fault on walk", {31'h0, f}, 0);
    chk(ph == 32'h8765_4ABC, "R4", "phys on walk", ph, 32'h8765_4ABC);
    chk(!ol_bad && !rdy_bad, "R8", "outstanding/ready during walk", {30'h0, ol_bad, rdy_bad}, 0);
    chk(!hold_bad, "R12", "request held under stall", {31'h0, hold_bad}, 0);
  endtask

  task automatic t_hit();
    logic [31:0] ph; logic f; int n, l;
    xlate(32'h0040_3123, ph, f, n, l);
    chk(l == 1, "R7", "hit latency", l, 1);
    chk(n == 0, "R7", "hit reads", n, 0);
    chk(ph == 32'h8765_4123 && !f, "R7", "hit phys", ph, 32'h8765_4123);
  endtask

  task automatic t_dir_fault();
    logic [31:0] ph; logic f; int n, l;
    xlate(32'hC000_0123, ph, f, n, l);
    chk(f, "R5", "dir absent fault", {31'h0, f}, 1);
    chk(n == 1, "R5", "dir absent reads", n, 1);
    chk(ph == 0, "R5", "fault phys", ph, 0);
  endtask

  task automatic t_tbl_fault();
    logic [31:0] ph; logic f; int n, l;
    xlate(32'h0040_7010, ph, f, n, l);
    chk(f && n == 2, "R6", "tbl absent fault/reads", n, 2);
    xlate(32'h0040_7010, ph, f, n, l);
    chk(f && n == 2, "R6", "repeat not cached", n, 2);
  endtask

  task automatic t_alias();
    logic [31:0] ph; logic f; int n, l;
    map_page(32'h0080_0000, 32'h1234_5000);
    map_page(32'hFF00_3000, 32'h1234_5000);
    xlate(32'h0080_0010, ph, f, n, l);
    chk(ph == 32'h1234_5010 && !f, "R11", "alias A phys", ph, 32'h1234_5010);
    xlate(32'hFF00_3020, ph, f, n, l);
    chk(ph == 32'h1234_5020 && !f, "R11", "alias B phys", ph, 32'h1234_5020);
    xlate(32'h0080_0030, ph, f, n, l);
    chk(n == 0 && ph == 32'h1234_5030, "R11", "alias A hit", n, 0);
    xlate(32'hFF00_3040, ph, f, n, l);
    chk(n == 0 && ph == 32'h1234_5040, "R11", "alias B hit", n, 0);
  endtask

  task automatic t_flush();
    logic [31:0] ph; logic f; int n, l;
    pulse_flush();
    xlate(32'h0040_3001, ph, f, n, l);
    chk(n == 2 && ph == 32'h8765_4001, "R10", "walk after flush", n, 2);
  endtask

  task automatic t_evict();
    logic [31:0] ph; logic f; int n, l;
    pulse_flush();
    for (int i = 1; i <= 9; i++) begin
      map_page(32'h0100_0000 + i * 32'h1000, 32'h0A00_0000 + i * 32'h1000);
      xlate(32'h0100_0000 + i * 32'h1000, ph, f, n, l);
    end
    xlate(32'h0100_1004, ph, f, n, l);
    chk(n == 2 && ph == 32'h0A00_1004, "R9", "oldest evicted", n, 2);
    xlate(32'h0100_3008, ph, f, n, l);
    chk(n == 0 && ph == 32'h0A00_3008, "R9", "third kept", n, 0);
    xlate(32'h0100_200C, ph, f, n, l);
    chk(n == 2 && ph == 32'h0A00_200C, "R9", "second evicted by refill", n, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_walk();
    t_hit();
    t_dir_fault();
    t_tbl_fault();
    t_alias();
    t_flush();
    t_evict();
    chk(!ol_bad && !rdy_bad && !hold_bad, "R12", "port rules over run",
        {29'h0, ol_bad, rdy_bad, hold_bad}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule